// File: doc/BRIEF.md
# Intra DC Prediction Reconstruction Unit

This unit restores the DC coefficients of intra-coded macroblocks when a variable-length decoder delivers them as prediction residuals. A macroblock holds four luma blocks (top-left, top-right, bottom-left, bottom-right) and two chroma blocks. For each block the unit looks at three already rebuilt neighbours: left (A), above (C) and above-left (B). A gradient test between them chooses the predictor. The predictor is divided by the block's DC scaler with rounding, the residual is added to the quotient, and the corrected value leaves the unit as a 12-bit sign-magnitude word.

The dequantised product (corrected value times scaler) is kept as neighbour context. Context from the previous macroblock sits in a small set of left registers. Context from the row above sits in a row buffer indexed by macroblock column. A single above-left register is refilled from the row buffer slot just before that slot is overwritten. Macroblocks must arrive in raster order. A neighbour outside the picture is replaced by the constant 1024.

The caller pulses `start` with the six residuals, the column index, the edge flags and the two scalers. The six corrected words then leave one at a time on a valid/ready stream, and `done` pulses once the last one has been taken.

Top module: `intra_dc_rebuild`

## Requirements
- R1: Residual words are 12-bit sign-magnitude. Bit 11 is the sign and bits 10:0 are the magnitude, so 12'h800 decodes as zero. Block k sits at `resid_bus[12k+11:12k]`, with k = 0..5 meaning top-left luma, top-right luma, bottom-left luma, bottom-right luma, Cb, Cr.
- R2: A corrected value q is emitted as {1'b1, (-q) mod 2048} when q < 0, and as {1'b0, q mod 2048} otherwise.
- R3: The predictor is C when |C - B| > |A - B|. Otherwise it is A, so a tie picks A.
- R4: The corrected value is residual + (P + s/2) / s, where P is the predictor, s is the block's scaler and both divisions truncate toward zero. Luma blocks use `luma_scale` and chroma blocks use `chroma_scale`. Scalers are non-zero.
- R5: Each block's stored neighbour value is its corrected value times its scaler. The luma neighbours (A, C, B) are:
  - top-left luma: left-MB top-right, above-MB bottom-left, above-left-MB bottom-right.
  - top-right luma: own top-left, above-MB bottom-right, above-MB bottom-left.
  - bottom-left luma: left-MB bottom-right, own top-left, left-MB top-right.
  - bottom-right luma: own bottom-left, own top-right, own top-left.
- R6: With `first_row` set, every above and above-left neighbour is 1024. With `first_col` set, every left and above-left neighbour is 1024.
- R7: Each chroma block takes A, C and B from the same chroma component of the left, above and above-left macroblocks.
- R8: Six words per macroblock leave in block order, with `out_blk` = k as in R1. A word and its index hold while `out_valid` is high and `out_ready` is low. Each accepted word drops `out_valid` for at least one cycle.
- R9: `done` is high for exactly the one cycle after the Cr word is accepted.
- R10: A `start` pulse that arrives while a macroblock is in progress, including in the cycle its last word is accepted, is ignored.
- R11: Above context for column c comes from the macroblock rebuilt at column c in the previous row. Above-left context comes from column c-1 in the previous row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch one macroblock (taken only when idle) |
| mb_col | input | COL_W | Column index of the macroblock |
| first_col | input | 1 | Macroblock is in the leftmost column |
| first_row | input | 1 | Macroblock is in the top row |
| resid_bus | input | 72 | Six 12-bit sign-magnitude residuals |
| luma_scale | input | SCALE_W | Luma DC scaler |
| chroma_scale | input | SCALE_W | Chroma DC scaler |
| out_valid | output | 1 | Corrected word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_word | output | 12 | Corrected DC, sign-magnitude |
| out_blk | output | 3 | Block index of `out_word` |
| done | output | 1 | One-cycle pulse after the last word is taken |

## Verification
Two events can meet in one cycle: the handover of the final Cr word, which also commits the row buffer, left and above-left context, and a fresh `start` from the caller. The bench provokes this collision on purpose. In the second picture it fires a stray start, carrying garbage residuals and scalers, in exactly the cycle the Cr word is accepted, and it fires another stray start in the middle of a macroblock. A behavioural picture model compares every accepted word and every `done` cycle against expectations under random backpressure, so a captured stray start or a misplaced commit shows up in the following macroblocks' words.

// File: rtl/dcp_pkg.sv
// Package dcp_pkg
// Shared constants and types for the intra DC reconstruction unit.
// Assumes 12-bit sign-magnitude DC words and six blocks per macroblock.
package dcp_pkg;
    localparam int WORD_W     = 12;
    localparam int MAG_W      = 11;
    localparam int N_BLK      = 6;
    localparam int DEFAULT_DC = 1024;
    localparam logic [2:0] LAST_BLK = 3'd5;

    typedef enum logic [1:0] {
        S_IDLE,
        S_PICK,
        S_DIV,
        S_OUT
    } dcp_state_e;
endpackage

// File: rtl/dcp_grad_pick.sv
// Module dcp_grad_pick
// Chooses the DC predictor from three neighbours by a gradient test:
// the above value wins only when its gradient against the above-left
// value is strictly larger than the left value's. Purely combinational.
// Assumes the inputs are signed values of W bits.
module dcp_grad_pick #(
    parameter int W = 20
) (
    input  logic signed [W-1:0] nb_left,
    input  logic signed [W-1:0] nb_diag,
    input  logic signed [W-1:0] nb_up,
    output logic signed [W-1:0] pred
);
    logic signed [W:0] d_up;
    logic signed [W:0] d_left;
    logic        [W:0] g_up;
    logic        [W:0] g_left;

    // Gradient magnitudes and the strict comparison
    always_comb begin
        d_up   = (W+1)'(nb_up)   - (W+1)'(nb_diag);
        d_left = (W+1)'(nb_left) - (W+1)'(nb_diag);
        g_up   = d_up[W]   ? (W+1)'(-d_up)   : d_up;
        g_left = d_left[W] ? (W+1)'(-d_left) : d_left;
        pred   = (g_up > g_left) ? nb_up : nb_left;
    end
endmodule

// File: rtl/dcp_seq_div.sv
// Module dcp_seq_div
// Restoring unsigned divider, one quotient bit per cycle. A go pulse
// loads the operands, and done pulses NUM_W+1 cycles later with the
// quotient on quot. Assumes den is non-zero and go is not pulsed while
// a division is running.
module dcp_seq_div #(
    parameter int NUM_W = 21,
    parameter int DEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] work;
    logic [DEN_W-1:0] rem;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] steps;
    logic             run;
    logic [DEN_W:0]   trial;
    logic             fits;

    assign trial = {rem, work[NUM_W-1]};
    assign fits  = (trial >= {1'b0, den_q});
    assign quot  = work;

    // Load operands, then shift one quotient bit in per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work  <= '0;
            rem   <= '0;
            den_q <= '0;
            steps <= '0;
            run   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                work  <= num;
                rem   <= '0;
                den_q <= den;
                steps <= CNT_W'(NUM_W);
                run   <= 1'b1;
            end else if (run) begin
                work  <= {work[NUM_W-2:0], fits};
                rem   <= fits ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
                steps <= steps - 1'b1;
                if (steps == CNT_W'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // The remainder never reaches the divisor once the quotient is out
    assert_rem_below_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem < den_q));

    // A new division is never launched over a running one
    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !run);
endmodule

// File: rtl/dcp_nbr_store.sv
// Module dcp_nbr_store
// Neighbour context for DC prediction. It holds the left macroblock's
// right and bottom values, one above-left copy and a row buffer with one
// slot per macroblock column. On commit, the slot for the current column
// moves into the above-left copy and is then overwritten with the current
// macroblock. Assumes raster order and col < COLS. All storage resets to
// the default DC value.
module dcp_nbr_store #(
    parameter int COLS  = 11,
    parameter int COL_W = 4,
    parameter int W     = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [COL_W-1:0]    col,
    input  logic signed [W-1:0] new_tr,
    input  logic signed [W-1:0] new_bl,
    input  logic signed [W-1:0] new_br,
    input  logic signed [W-1:0] new_cb,
    input  logic signed [W-1:0] new_cr,
    output logic signed [W-1:0] lf_tr,
    output logic signed [W-1:0] lf_br,
    output logic signed [W-1:0] lf_cb,
    output logic signed [W-1:0] lf_cr,
    output logic signed [W-1:0] up_bl,
    output logic signed [W-1:0] up_br,
    output logic signed [W-1:0] up_cb,
    output logic signed [W-1:0] up_cr,
    output logic signed [W-1:0] dg_br,
    output logic signed [W-1:0] dg_cb,
    output logic signed [W-1:0] dg_cr
);
    import dcp_pkg::*;

    localparam logic signed [W-1:0] DEF_V = W'(DEFAULT_DC);

    logic signed [W-1:0] row_bl [COLS];
    logic signed [W-1:0] row_br [COLS];
    logic signed [W-1:0] row_cb [COLS];
    logic signed [W-1:0] row_cr [COLS];

    assign up_bl = row_bl[col];
    assign up_br = row_br[col];
    assign up_cb = row_cb[col];
    assign up_cr = row_cr[col];

    for (genvar g = 0; g < COLS; g++) begin : g_slot
        // Row buffer slot g takes the current macroblock when its column commits
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_bl[g] <= DEF_V;
                row_br[g] <= DEF_V;
                row_cb[g] <= DEF_V;
                row_cr[g] <= DEF_V;
            end else if (commit && (col == COL_W'(g))) begin
                row_bl[g] <= new_bl;
                row_br[g] <= new_br;
                row_cb[g] <= new_cb;
                row_cr[g] <= new_cr;
            end
        end
    end

    // Left context follows every committed macroblock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lf_tr <= DEF_V;
            lf_br <= DEF_V;
            lf_cb <= DEF_V;
            lf_cr <= DEF_V;
        end else if (commit) begin
            lf_tr <= new_tr;
            lf_br <= new_br;
            lf_cb <= new_cb;
            lf_cr <= new_cr;
        end
    end

    // Above-left copy keeps the slot contents that are about to be replaced
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dg_br <= DEF_V;
            dg_cb <= DEF_V;
            dg_cr <= DEF_V;
        end else if (commit) begin
            dg_br <= row_br[col];
            dg_cb <= row_cb[col];
            dg_cr <= row_cr[col];
        end
    end

    // The column index addresses an existing row buffer slot
    assert_col_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (int'(col) < COLS));

    // The above-left copy changes only on a commit
    assert_diag_only_on_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(dg_br) && $stable(dg_cb) && $stable(dg_cr));
endmodule

// File: rtl/intra_dc_rebuild.sv
// Module intra_dc_rebuild
// Rebuilds intra DC coefficients from the decoder's prediction residuals.
// The block sequence for each macroblock is: pick the neighbours, choose
// the predictor, divide it by the scaler with rounding, add the residual,
// emit the word and keep the scaled value. Assumes macroblocks arrive in
// raster order, scalers are non-zero and inputs are held only for the
// start cycle.
module intra_dc_rebuild #(
    parameter int MAX_MB_COLS = 11,
    parameter int SCALE_W     = 6,
    parameter int ACC_W       = 20,
    localparam int COL_W      = (MAX_MB_COLS > 1) ? $clog2(MAX_MB_COLS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [COL_W-1:0]   mb_col,
    input  logic               first_col,
    input  logic               first_row,
    input  logic [71:0]        resid_bus,
    input  logic [SCALE_W-1:0] luma_scale,
    input  logic [SCALE_W-1:0] chroma_scale,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [11:0]        out_word,
    output logic [2:0]         out_blk,
    output logic               done
);
    import dcp_pkg::*;

    localparam int NUM_W = ACC_W + 1;
    localparam logic signed [ACC_W-1:0] DEF_V = ACC_W'(DEFAULT_DC);

    dcp_state_e                state;
    logic [2:0]                blk;
    logic [WORD_W*N_BLK-1:0]   res_q;
    logic [SCALE_W-1:0]        ls_q;
    logic [SCALE_W-1:0]        cs_q;
    logic [COL_W-1:0]          col_q;
    logic                      fc_q;
    logic                      fr_q;
    logic                      n_neg;
    logic signed [ACC_W-1:0]   cur [N_BLK];

    logic signed [ACC_W-1:0]   lf_tr, lf_br, lf_cb, lf_cr;
    logic signed [ACC_W-1:0]   up_bl, up_br, up_cb, up_cr;
    logic signed [ACC_W-1:0]   dg_br, dg_cb, dg_cr;
    logic signed [ACC_W-1:0]   nb_a, nb_b, nb_c, pred;
    logic [SCALE_W-1:0]        cur_s;
    logic signed [NUM_W-1:0]   n_sum;
    logic [NUM_W-1:0]          n_mag;
    logic                      div_go, div_done;
    logic [NUM_W-1:0]          quot;
    logic [WORD_W-1:0]         res_word;
    logic signed [ACC_W-1:0]   res_val, q_val, qdc, prod, s_ext;
    logic [WORD_W-1:0]         enc;
    logic                      commit;

    assign out_blk = blk;
    assign div_go  = (state == S_PICK);
    assign commit  = (state == S_OUT) && out_ready && (blk == LAST_BLK);

    // Neighbour selection per block, with 1024 outside the picture
    always_comb begin
        nb_a = DEF_V;
        nb_b = DEF_V;
        nb_c = DEF_V;
        case (blk)
            3'd0: begin
                if (!fc_q)          nb_a = lf_tr;
                if (!fr_q)          nb_c = up_bl;
                if (!fc_q && !fr_q) nb_b = dg_br;
            end
            3'd1: begin
                nb_a = cur[0];
                if (!fr_q) begin
                    nb_c = up_br;
                    nb_b = up_bl;
                end
            end
            3'd2: begin
                if (!fc_q) begin
                    nb_a = lf_br;
                    nb_b = lf_tr;
                end
                nb_c = cur[0];
            end
            3'd3: begin
                nb_a = cur[2];
                nb_c = cur[1];
                nb_b = cur[0];
            end
            3'd4: begin
                if (!fc_q)          nb_a = lf_cb;
                if (!fr_q)          nb_c = up_cb;
                if (!fc_q && !fr_q) nb_b = dg_cb;
            end
            default: begin
                if (!fc_q)          nb_a = lf_cr;
                if (!fr_q)          nb_c = up_cr;
                if (!fc_q && !fr_q) nb_b = dg_cr;
            end
        endcase
    end

    dcp_grad_pick #(.W(ACC_W)) u_pick (
        .nb_left (nb_a),
        .nb_diag (nb_b),
        .nb_up   (nb_c),
        .pred    (pred)
    );

    // Rounded dividend and its magnitude for the unsigned divider
    always_comb begin
        cur_s = (blk >= 3'd4) ? cs_q : ls_q;
        n_sum = NUM_W'(pred) + NUM_W'({1'b0, cur_s >> 1});
        n_mag = n_sum[NUM_W-1] ? NUM_W'(-n_sum) : NUM_W'(n_sum);
    end

    dcp_seq_div #(.NUM_W(NUM_W), .DEN_W(SCALE_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (n_mag),
        .den   (cur_s),
        .done  (div_done),
        .quot  (quot)
    );

    // Residual decode, correction, scaling and sign-magnitude encode
    always_comb begin
        res_word = res_q[blk*WORD_W +: WORD_W];
        res_val  = res_word[WORD_W-1] ? -ACC_W'(res_word[MAG_W-1:0])
                                      :  ACC_W'(res_word[MAG_W-1:0]);
        q_val    = n_neg ? -ACC_W'(quot) : ACC_W'(quot);
        qdc      = res_val + q_val;
        s_ext    = ACC_W'(cur_s);
        prod     = qdc * s_ext;
        enc      = qdc[ACC_W-1] ? {1'b1, MAG_W'(-qdc)} : {1'b0, MAG_W'(qdc)};
    end

    // Macroblock sequencer: capture, predict, divide, emit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            blk       <= '0;
            res_q     <= '0;
            ls_q      <= SCALE_W'(1);
            cs_q      <= SCALE_W'(1);
            col_q     <= '0;
            fc_q      <= 1'b1;
            fr_q      <= 1'b1;
            n_neg     <= 1'b0;
            out_valid <= 1'b0;
            out_word  <= '0;
            done      <= 1'b0;
            for (int i = 0; i < N_BLK; i++) cur[i] <= DEF_V;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    res_q <= resid_bus;
                    ls_q  <= luma_scale;
                    cs_q  <= chroma_scale;
                    col_q <= mb_col;
                    fc_q  <= first_col;
                    fr_q  <= first_row;
                    blk   <= '0;
                    state <= S_PICK;
                end
                S_PICK: begin
                    n_neg <= n_sum[NUM_W-1];
                    state <= S_DIV;
                end
                S_DIV: if (div_done) begin
                    cur[blk]  <= prod;
                    out_word  <= enc;
                    out_valid <= 1'b1;
                    state     <= S_OUT;
                end
                default: if (out_ready) begin
                    out_valid <= 1'b0;
                    if (blk == LAST_BLK) begin
                        done  <= 1'b1;
                        blk   <= '0;
                        state <= S_IDLE;
                    end else begin
                        blk   <= blk + 1'b1;
                        state <= S_PICK;
                    end
                end
            endcase
        end
    end

    dcp_nbr_store #(.COLS(MAX_MB_COLS), .COL_W(COL_W), .W(ACC_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .col    (col_q),
        .new_tr (cur[1]),
        .new_bl (cur[2]),
        .new_br (cur[3]),
        .new_cb (cur[4]),
        .new_cr (cur[5]),
        .lf_tr  (lf_tr),
        .lf_br  (lf_br),
        .lf_cb  (lf_cb),
        .lf_cr  (lf_cr),
        .up_bl  (up_bl),
        .up_br  (up_br),
        .up_cb  (up_cb),
        .up_cr  (up_cr),
        .dg_br  (dg_br),
        .dg_cb  (dg_cb),
        .dg_cr  (dg_cr)
    );

    // A stalled word and its index stay put until accepted
    assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_blk));

    // Each accepted word is a single beat
    assert_single_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid);

    // done follows the acceptance of the Cr word and nothing else
    assert_done_after_cr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready && (out_blk == LAST_BLK)));

    // A launch always carries usable scalers
    assert_scale_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start && (state == S_IDLE) |-> (luma_scale != '0) && (chroma_scale != '0));

    // A start during processing leaves the captured inputs untouched
    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(res_q) && $stable(ls_q) && $stable(cs_q) && $stable(col_q));
endmodule

// File: tb/sim_intra_dc_rebuild.sv
// Bench for intra_dc_rebuild. A behavioural picture model predicts every
// output word, and each clock's handshake and done flag are compared
// against it under random backpressure.
module sim_intra_dc_rebuild;
    localparam int COLS  = 11;
    localparam int COL_W = $clog2(COLS);
    localparam int PW    = 3;
    localparam int PH    = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             drv_start, mon_start, start;
    logic [COL_W-1:0] mb_col;
    logic             first_col, first_row;
    logic [71:0]      resid_bus;
    logic [5:0]       luma_scale, chroma_scale;
    logic             out_valid, out_ready, done;
    logic [11:0]      out_word;
    logic [2:0]       out_blk;

    int          checks = 0;
    int          fails  = 0;
    int          cycles = 0;
    int unsigned seed   = 32'h1234_5678;
    int          mdl [PW][PH][6];
    int          exp_q [$];
    bit          pend_done = 1'b0;
    bit          stray_cr  = 1'b0;

    assign start = drv_start | mon_start;

    always #5 clk = ~clk;

    intra_dc_rebuild u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .mb_col       (mb_col),
        .first_col    (first_col),
        .first_row    (first_row),
        .resid_bus    (resid_bus),
        .luma_scale   (luma_scale),
        .chroma_scale (chroma_scale),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_word     (out_word),
        .out_blk      (out_blk),
        .done         (done)
    );

    function automatic int unsigned nxt();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 16;
    endfunction

    function automatic int nb(int c, int r, int k);
        if (c < 0 || r < 0) return 1024;
        return mdl[c][r][k];
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int smdec(int w);
        return ((w & 'h800) != 0) ? -(w & 'h7ff) : (w & 'h7ff);
    endfunction

    function automatic int smenc(int q);
        return (q < 0) ? (((-q) & 'h7ff) | 'h800) : (q & 'h7ff);
    endfunction

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired, actual hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Per-clock monitor: done check, ready pattern, handshake compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend_done || done) begin
                checks++;
                if (done !== pend_done) begin
                    fails++;
                    $display("FAIL R9 done actual %0b expected %0b", done, pend_done);
                end
            end
            pend_done = 1'b0;
            mon_start = 1'b0;
            out_ready = (nxt() % 4) != 0;
            if (out_valid && out_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R8 word actual %03h blk %0d expected none", out_word, out_blk);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    if (out_word !== e[11:0] || out_blk !== e[14:12]) begin
                        fails++;
                        if (e[14:12] < 3'd4)
                            $display("FAIL R1 R2 R3 R4 R5 R6 R8 R10 R11 luma actual %03h/%0d expected %03h/%0d",
                                     out_word, out_blk, e[11:0], e[14:12]);
                        else
                            $display("FAIL R1 R2 R3 R4 R6 R7 R8 R10 R11 chroma actual %03h/%0d expected %03h/%0d",
                                     out_word, out_blk, e[11:0], e[14:12]);
                    end
                end
                if (out_blk == 3'd5) begin
                    pend_done = 1'b1;
                    if (stray_cr) mon_start = 1'b1;  // R10: start collides with final handover
                end
            end
        end
    end

    // Model one macroblock, queue its words, drive it and wait for done
    task automatic run_mb(int c, int r, int pic);
        int res [6];
        int a, b, cc, p, s, q;
        int ls, cs;
        logic [71:0] bus;
        if (pic == 0) begin
            ls = (c + r * 3) % 5 == 0 ? 8 : (c + r * 3) % 5 == 1 ? 5 :
                 (c + r * 3) % 5 == 2 ? 13 : (c + r * 3) % 5 == 3 ? 1 : 32;
            cs = (c + r) % 3 == 0 ? 8 : (c + r) % 3 == 1 ? 9 : 3;
        end else begin
            ls = (c + r * 3) % 4 == 0 ? 3 : (c + r * 3) % 4 == 1 ? 17 :
                 (c + r * 3) % 4 == 2 ? 7 : 2;
            cs = (c + r) % 3 == 0 ? 9 : (c + r) % 3 == 1 ? 1 : 4;
        end
        for (int k = 0; k < 6; k++) begin
            int mag, neg;
            if (nxt() % 9 == 0) res[k] = 'h800;  // R1: negative zero
            else begin
                mag = (pic == 0) ? int'(nxt() % 61) : int'(nxt() % 251);
                neg = (pic == 0) ? int'(nxt() % 3 == 0) : int'(nxt() % 4 != 0);
                res[k] = neg ? (mag | 'h800) : mag;
            end
            bus[k*12 +: 12] = res[k][11:0];
        end
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: begin a = nb(c-1, r, 1); cc = nb(c, r-1, 2); b = nb(c-1, r-1, 3); end
                1: begin a = mdl[c][r][0]; cc = nb(c, r-1, 3); b = nb(c, r-1, 2); end
                2: begin a = nb(c-1, r, 3); cc = mdl[c][r][0]; b = nb(c-1, r, 1); end
                3: begin a = mdl[c][r][2]; cc = mdl[c][r][1]; b = mdl[c][r][0]; end
                default: begin a = nb(c-1, r, k); cc = nb(c, r-1, k); b = nb(c-1, r-1, k); end
            endcase
            p = (iabs(cc - b) > iabs(a - b)) ? cc : a;
            s = (k < 4) ? ls : cs;
            q = smdec(res[k]) + (p + s / 2) / s;
            mdl[c][r][k] = q * s;
            exp_q.push_back((k << 12) | smenc(q));
        end
        @(negedge clk);
        drv_start    = 1'b1;
        mb_col       = COL_W'(c);
        first_col    = (c == 0);
        first_row    = (r == 0);
        resid_bus    = bus;
        luma_scale   = 6'(ls);
        chroma_scale = 6'(cs);
        @(negedge clk);
        drv_start    = 1'b0;
        resid_bus    = {6{12'h7a5}};
        luma_scale   = 6'd37;
        chroma_scale = 6'd11;
        mb_col       = COL_W'(COLS - 1);
        first_col    = 1'b1;
        first_row    = 1'b1;
        if (pic == 1) begin
            repeat (6) @(negedge clk);
            drv_start = 1'b1;  // R10: stray start mid-macroblock
            @(negedge clk);
            drv_start = 1'b0;
        end
        do @(negedge clk); while (!done);
    endtask

    initial begin
        rst_n        = 1'b0;
        drv_start    = 1'b0;
        mon_start    = 1'b0;
        out_ready    = 1'b0;
        mb_col       = '0;
        first_col    = 1'b1;
        first_row    = 1'b1;
        resid_bus    = '0;
        luma_scale   = 6'd8;
        chroma_scale = 6'd8;
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || done !== 1'b0) begin
            fails++;
            $display("FAIL R8 R9 reset actual valid %0b done %0b expected 0 0", out_valid, done);
        end
        rst_n = 1'b1;
        for (int r = 0; r < PH; r++)
            for (int c = 0; c < PW; c++)
                run_mb(c, r, 0);
        stray_cr = 1'b1;
        for (int r = 0; r < PH; r++)
            for (int c = 0; c < PW; c++)
                run_mb(c, r, 1);
        stray_cr = 1'b0;
        repeat (40) @(negedge clk);
        checks++;
        if (exp_q.size() != 0 || out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R8 R10 leftover actual %0d words valid %0b expected 0 0", exp_q.size(), out_valid);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule